// File: doc/BRIEF.md
# Dual-Image Boot Address Sequencer

This block drives the read address for a parallel flash that holds two configuration images, one placed at the bottom of a 24-bit address space and one at the top. After the hard reset input is released, the sequencer reads one image. A mode input chooses the image: mode low starts at address 0 and counts up, and mode high starts at 0xFFFFFF and counts down. Each read cycle is marked by a one-cycle read strobe. After a fixed number of reads, set by a parameter, the sequencer drops busy, raises done and waits.

Logic running from the loaded image can ask for the other image by pulling an active-low reboot request. The request has effect only when the reboot feature is enabled, only when the sequencer is idle, and only when the request stays low for at least a parameter number of clock cycles. The reload starts when the request is released, not when it falls. Each qualified request switches the read to the end of memory opposite the one used last and reverses the walking direction. A later request switches back again. Pulling the hard reset low cancels all of this and returns to the end the mode input selects.

Top module: `dual_image_boot_seq`

## Requirements
- R1: After hard reset is released with `mode_top` = 0, the load reads addresses 0, 1, 2, ... with exactly one address per `rd_stb` cycle.
- R2: After hard reset is released with `mode_top` = 1, the load reads addresses 0xFFFFFF, 0xFFFFFE, ... with exactly one address per `rd_stb` cycle.
- R3: A load produces exactly IMG_LEN strobes. While the load runs, `busy` = 1 and `done` = 0. After the last strobe, `done` = 1, `busy` = 0 and `rd_stb` = 0 until the next load.
- R4: A qualified request starts no read while `reboot_n` is still low. The reload begins only after `reboot_n` returns high.
- R5: A qualified request reloads from the end opposite the previous load, and the address moves the opposite way. `from_top` = 1 means the current load started at 0xFFFFFF and counts down.
- R6: Successive qualified requests alternate between the two ends. A request held low for exactly MIN_LOW cycles qualifies.
- R7: A request held low for fewer than MIN_LOW cycles is ignored. No strobe follows it and `done` stays 1.
- R8: While `reboot_en` = 0, requests of any width are ignored.
- R9: A request made while a load is in progress is ignored. Low cycles during the load do not count toward the minimum width.
- R10: While `rst_n` = 0, `rd_stb` = 0, `busy` = 1 and `done` = 0. Releasing reset always starts from the end that `mode_top` selects, whatever reloads happened before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| mode_top | input | 1 | Start end after hard reset: 0 = address 0 counting up, 1 = 0xFFFFFF counting down |
| reboot_en | input | 1 | Enables reboot requests |
| reboot_n | input | 1 | Active-low reboot request, asynchronous to clk |
| flash_addr | output | ADDR_W | Current flash read address |
| rd_stb | output | 1 | High for one cycle per read of `flash_addr` |
| busy | output | 1 | A load is being set up or running |
| done | output | 1 | The last load has finished |
| from_top | output | 1 | The current or last load started at the top end |

## Verification
The main function is tried with four kinds of request pulse:
- **Below the minimum width.** Separates a correct width qualifier from one that is off by one.
- **Exactly the minimum width.** Also separates a correct qualifier from an off-by-one one.
- **Held well beyond the minimum, with the output watched during the low phase.** Shows whether the reload waits for the release edge.
- **Made during a load.** Shows whether low cycles during a load are wrongly counted.

The scoreboard checks each of these loads address by address and flags any extra strobe. This tells a correct start end and direction apart from swapped or off-by-one walking.

Hard reset is then applied with each mode value after several reloads. This shows that the reset selection does not depend on the reload history.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    // Sequencer phase: INIT latches the mode, LOAD walks, IDLE waits.
    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_LOAD = 2'd1,
        PH_IDLE = 2'd2
    } boot_phase_e;

endpackage

// File: rtl/boot_trig_sync.sv
module boot_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] sync_d;

    always_comb begin
        sync_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    // Idle level of the request is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/boot_trig_qual.sv
module boot_trig_qual #(
    parameter int MIN_LOW = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic blocked,
    input  logic req_n_s,
    output logic fire
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] LMAX = LW'(MIN_LOW);

    logic [LW-1:0] low_cnt_q;
    logic [LW-1:0] low_cnt_d;

    always_comb begin
        if (!enable || blocked) begin
            low_cnt_d = '0;
        end else if (!req_n_s) begin
            low_cnt_d = (low_cnt_q == LMAX) ? LMAX : low_cnt_q + 1'b1;
        end else begin
            low_cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt_q <= '0;
        else        low_cnt_q <= low_cnt_d;
    end

    // Fire when the request comes back high after a long enough low phase.
    assign fire = enable && !blocked && req_n_s && (low_cnt_q == LMAX);
endmodule

// File: rtl/boot_addr_walk.sv
module boot_addr_walk #(
    parameter int ADDR_W  = 24,
    parameter int IMG_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              go_down,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int CW = $clog2(IMG_LEN + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(IMG_LEN - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CW-1:0]     idx;
        logic              down;
    } walk_t;

    walk_t w_q;
    walk_t w_d;

    always_comb begin
        w_d = w_q;
        if (restart) begin
            w_d.addr = go_down ? '1 : '0;
            w_d.idx  = '0;
            w_d.down = go_down;
        end else if (step) begin
            w_d.addr = w_q.down ? w_q.addr - 1'b1 : w_q.addr + 1'b1;
            w_d.idx  = w_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign addr = w_q.addr;
    assign last = (w_q.idx == LAST_IDX);
endmodule

// File: rtl/dual_image_boot_seq.sv
module dual_image_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int IMG_LEN     = 16,
    parameter int MIN_LOW     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_top,
    input  logic              reboot_en,
    input  logic              reboot_n,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              rd_stb,
    output logic              busy,
    output logic              done,
    output logic              from_top
);
    typedef struct packed {
        boot_phase_e phase;
        logic        top;
    } seq_t;

    seq_t s_q;
    seq_t s_d;

    logic req_s;
    logic fire;
    logic restart;
    logic walk_last;

    boot_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (reboot_n),
        .dout  (req_s)
    );

    boot_trig_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (reboot_en),
        .blocked (busy),
        .req_n_s (req_s),
        .fire    (fire)
    );

    always_comb begin
        s_d     = s_q;
        restart = 1'b0;
        unique case (s_q.phase)
            PH_INIT: begin
                s_d.top   = mode_top;
                s_d.phase = PH_LOAD;
                restart   = 1'b1;
            end
            PH_LOAD: begin
                if (walk_last) s_d.phase = PH_IDLE;
            end
            PH_IDLE: begin
                if (fire) begin
                    s_d.top   = !s_q.top;
                    s_d.phase = PH_LOAD;
                    restart   = 1'b1;
                end
            end
            default: s_d.phase = PH_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_INIT, top: 1'b0};
        else        s_q <= s_d;
    end

    boot_addr_walk #(.ADDR_W(ADDR_W), .IMG_LEN(IMG_LEN)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .go_down (s_d.top),
        .step    (rd_stb),
        .addr    (flash_addr),
        .last    (walk_last)
    );

    assign rd_stb   = (s_q.phase == PH_LOAD);
    assign busy     = (s_q.phase != PH_IDLE);
    assign done     = (s_q.phase == PH_IDLE);
    assign from_top = s_q.top;
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reboot_en,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              rd_stb,
    input logic              busy,
    input logic              done,
    input logic              from_top
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    p_stb_in_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (busy && !done));

    p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && $past(rd_stb) && !$past(from_top)) |-> flash_addr == $past(flash_addr) + 1'b1);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && $past(rd_stb) && $past(from_top)) |-> flash_addr == $past(flash_addr) - 1'b1);

    p_reload_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (flash_addr == (from_top ? TOP_ADDR : '0)));

    p_reload_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (from_top != $past(from_top)));

    p_disabled_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reboot_en) |=> done);
endmodule

bind dual_image_boot_seq boot_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reboot_en  (reboot_en),
    .flash_addr (flash_addr),
    .rd_stb     (rd_stb),
    .busy       (busy),
    .done       (done),
    .from_top   (from_top)
);

// File: tb/dual_image_boot_seq_bench.sv
module dual_image_boot_seq_bench;
    localparam int AW      = 24;
    localparam int IMG_LEN = 16;
    localparam int MIN_LOW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_top = 1'b0;
    logic          reboot_en = 1'b0;
    logic          reboot_n = 1'b1;
    logic [AW-1:0] flash_addr;
    logic          rd_stb, busy, done, from_top;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic [AW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    dual_image_boot_seq #(.ADDR_W(AW), .IMG_LEN(IMG_LEN), .MIN_LOW(MIN_LOW)) u_dual_image_boot_seq (
        .clk(clk), .rst_n(rst_n), .mode_top(mode_top), .reboot_en(reboot_en),
        .reboot_n(reboot_n), .flash_addr(flash_addr), .rd_stb(rd_stb),
        .busy(busy), .done(done), .from_top(from_top)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_load(input bit top);
        for (int i = 0; i < IMG_LEN; i++) begin
            exp_q.push_back(top ? (AW'('1) - AW'(i)) : AW'(i));
        end
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        reboot_n = 1'b0;
        repeat (n) @(negedge clk);
        reboot_n = 1'b1;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        @(negedge clk);
        while (!(done && exp_q.size() == 0) && t < 200) begin
            @(negedge clk);
            t++;
        end
        // R3: load complete with all strobes seen and outputs at rest
        check(done && !busy && !rd_stb, {req, "/R3 end state"}, {busy, done, rd_stb}, 3'b010);
        check(exp_q.size() == 0, {req, "/R3 strobe count"}, AW'(exp_q.size()), '0);
    endtask

    task automatic quiet(input string req, input int n);
        repeat (n) @(negedge clk);
        check(done && !busy, req, {busy, done}, 2'b01);
    endtask

    // Scoreboard monitor: every strobe must match the next expected address.
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8/R9 unexpected strobe", flash_addr, '0);
            end else begin
                logic [AW-1:0] e;
                e = exp_q.pop_front();
                check(flash_addr == e, "R1/R2/R5 address", flash_addr, e);
                check(busy && !done, "R3 busy during load", {busy, done}, 2'b10);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!rd_stb && busy && !done, "R10 reset outputs", {rd_stb, busy, done}, 3'b010);
        push_load(1'b0);
        rst_n = 1'b1;
        wait_done("R1");
        check(from_top == 1'b0, "R1 from_top", from_top, 0);

        // R8: disabled, long pulse ignored
        pulse(MIN_LOW + 10);
        quiet("R8 disabled ignore", 40);

        reboot_en = 1'b1;
        // R7: one cycle too short
        pulse(MIN_LOW - 1);
        quiet("R7 short pulse", 40);

        // R4: held low well past minimum, nothing starts until release
        push_load(1'b1);
        @(negedge clk);
        reboot_n = 1'b0;
        repeat (MIN_LOW + 10) @(negedge clk);
        check(!rd_stb && !busy, "R4 no start while low", {rd_stb, busy}, 2'b00);
        reboot_n = 1'b1;
        wait_done("R5");
        check(from_top == 1'b1, "R5 from_top after flip", from_top, 1);

        // R6: exact minimum width, back to bottom
        push_load(1'b0);
        pulse(MIN_LOW);
        wait_done("R6");
        check(from_top == 1'b0, "R6 alternate back", from_top, 0);

        // R9: request made during a load is ignored
        push_load(1'b1);
        pulse(MIN_LOW);
        while (!busy) @(negedge clk);
        pulse(MIN_LOW);
        wait_done("R9 load");
        quiet("R9 busy request ignored", 40);
        check(from_top == 1'b1, "R9 end unchanged", from_top, 1);

        // R10: hard reset returns to mode end, first with mode 0
        push_load(1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(!rd_stb && busy && !done, "R10 reset outputs again", {rd_stb, busy, done}, 3'b010);
        rst_n = 1'b1;
        wait_done("R10 mode0");
        check(from_top == 1'b0, "R10 mode0 end", from_top, 0);

        // R2 and R10 with mode 1, then R5 flip down to bottom
        mode_top = 1'b1;
        push_load(1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wait_done("R2");
        check(from_top == 1'b1, "R2 mode1 end", from_top, 1);
        push_load(1'b0);
        pulse(MIN_LOW + 3);
        wait_done("R5 from top");
        check(from_top == 1'b0, "R5 flip to bottom", from_top, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule